// File: doc/BRIEF.md
# Latency Timer Packet Flush

This block sits beside a receive FIFO whose contents are waiting to be sent to the host. When bytes have been waiting without forming a full packet for longer than a programmable latency, it raises a one-cycle request that asks the packet logic to send the short packet as it is. Time is measured in 125 µs microframe ticks, eight to the millisecond. The latency is given in milliseconds, from 0 to 256.

The timer runs only while the FIFO holds data and no full packet is pending. It restarts whenever new data arrives (the occupancy rises), whenever a packet is taken, and after each flush. A latency value presented on the input is latched only at those restart points, so a change made in the middle of a period does not disturb that period. A latched latency of 0 turns the timer into a plain per-microframe flush: every tick while data is waiting produces a request.

Top module: `latency_flush`

## Requirements
- R1: Reset is synchronous and active low. While it is low and in the first cycle after it, `flush_req` is 0. The reset loads a latched latency of 16 ms and takes the current occupancy as the reference level, so steady data present at reset flushes on the 128th tick after reset.
- R2: With a latched latency of N ms (N ≥ 1), the timer counts `uframe_tick` pulses while running. The N·8-th tick after a restart raises `flush_req` for exactly one cycle, in the clock cycle after the edge that samples that tick.
- R3: With a latched latency of 0, every tick sampled while the FIFO is non-empty and `pkt_full` is low raises a flush request, even in a cycle with a restart event.
- R4: While `fifo_level` is 0, no flush request is issued and the timer is held at zero.
- R5: While `pkt_full` is high, no flush request is issued and the timer is held at zero. Counting resumes from zero when it falls.
- R6: A rise of `fifo_level` or a high `pkt_taken` restarts the timer from zero. When the latched latency is not 0, a restart wins over an expiry in the same cycle, and no request is issued.
- R7: `latency_ms` is latched only at a restart or a flush. Values above 256 are latched as 256.
- R8: After a flush the timer restarts, so steady data keeps flushing once per period.
- R9: A fall of `fifo_level` that leaves it non-zero does not restart the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| uframe_tick | input | 1 | One-cycle pulse each 125 µs microframe |
| fifo_level | input | LEVEL_W | Receive FIFO occupancy in bytes |
| pkt_full | input | 1 | A full packet is ready in the FIFO |
| pkt_taken | input | 1 | The packet logic took a packet this cycle |
| latency_ms | input | LAT_W | Programmed latency in milliseconds |
| flush_req | output | 1 | One-cycle request to send a short packet |

## Verification
The hardest case to reach from the ports is a restart event arriving in the very cycle whose tick would expire the timer. The bench gets there by counting ticks one at a time from a known restart. It brings the count to one short of the period, then drives the final tick and `pkt_taken` on the same edge. It then checks that no request appears and that a full fresh period is needed before the next one. The clamp at 256 ms is reached by latching an oversized value and running all 2048 ticks.

// File: rtl/latency_flush.sv
module latency_flush #(
  parameter int LEVEL_W      = 12,
  parameter int LAT_W        = 9,
  parameter int MAX_MS       = 256,
  parameter int DEFAULT_MS   = 16,
  parameter int TICKS_PER_MS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               uframe_tick,
  input  logic [LEVEL_W-1:0] fifo_level,
  input  logic               pkt_full,
  input  logic               pkt_taken,
  input  logic [LAT_W-1:0]   latency_ms,
  output logic               flush_req
);
  localparam int CNT_W = $clog2(MAX_MS * TICKS_PER_MS + 1);

  logic [LEVEL_W-1:0] prev_level;
  logic [LAT_W-1:0]   lim_q;
  logic [CNT_W-1:0]   cnt_q;

  logic [LAT_W-1:0]   lat_clamped;
  logic [CNT_W-1:0]   lim_ticks;
  logic               run, restart, zero_mode, hit;

  assign lat_clamped = (latency_ms > LAT_W'(MAX_MS)) ? LAT_W'(MAX_MS) : latency_ms;
  assign lim_ticks   = CNT_W'(lim_q) * CNT_W'(TICKS_PER_MS);
  assign run         = (fifo_level != '0) && !pkt_full;
  assign restart     = (fifo_level > prev_level) || pkt_taken;
  assign zero_mode   = (lim_q == '0);
  assign hit         = run && uframe_tick &&
                       (zero_mode || (!restart && cnt_q == lim_ticks - CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_level <= fifo_level;
      lim_q      <= LAT_W'(DEFAULT_MS);
      cnt_q      <= '0;
      flush_req  <= 1'b0;
    end else begin
      prev_level <= fifo_level;
      flush_req  <= hit;
      if (restart || hit)
        lim_q <= lat_clamped;
      if (!run || restart || hit)
        cnt_q <= '0;
      else if (uframe_tick)
        cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/latency_flush_chk.sv
module latency_flush_chk #(
  parameter int LEVEL_W      = 12,
  parameter int LAT_W        = 9,
  parameter int MAX_MS       = 256,
  parameter int TICKS_PER_MS = 8,
  parameter int CNT_W        = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               uframe_tick,
  input logic [LEVEL_W-1:0] fifo_level,
  input logic               pkt_full,
  input logic               pkt_taken,
  input logic               flush_req,
  input logic [LAT_W-1:0]   lim_q,
  input logic [CNT_W-1:0]   cnt_q
);
  p_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> $past(uframe_tick));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAX_MS * TICKS_PER_MS));

  p_no_empty_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> ($past(fifo_level) != '0));

  p_full_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pkt_full) |-> !flush_req);

  p_taken_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pkt_taken && lim_q != '0) |-> !flush_req);

  p_lim_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lim_q <= LAT_W'(MAX_MS));
endmodule

bind latency_flush latency_flush_chk #(
  .LEVEL_W(LEVEL_W), .LAT_W(LAT_W), .MAX_MS(MAX_MS),
  .TICKS_PER_MS(TICKS_PER_MS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .uframe_tick(uframe_tick),
  .fifo_level(fifo_level), .pkt_full(pkt_full), .pkt_taken(pkt_taken),
  .flush_req(flush_req), .lim_q(lim_q), .cnt_q(cnt_q)
);

// File: tb/test_latency_flush.sv
module test_latency_flush;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        uframe_tick = 1'b0;
  logic [11:0] fifo_level = '0;
  logic        pkt_full = 1'b0;
  logic        pkt_taken = 1'b0;
  logic [8:0]  latency_ms = '0;
  logic        flush_req;

  int checks = 0;
  int errors = 0;
  int nflush = 0;
  int mark = 0;
  longint cycles = 0;

  latency_flush i_latency_flush (
    .clk(clk), .rst_n(rst_n), .uframe_tick(uframe_tick),
    .fifo_level(fifo_level), .pkt_full(pkt_full), .pkt_taken(pkt_taken),
    .latency_ms(latency_ms), .flush_req(flush_req)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (flush_req) nflush++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: actual hung run, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) uframe_tick = 1'b1;
      @(negedge clk) uframe_tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_flushes(input int exp, input string req);
    idle(1);
    #1;
    checks++;
    if (nflush - mark != exp) begin
      errors++;
      $display("FAIL %s: flushes actual %0d expected %0d", req, nflush - mark, exp);
    end
    mark = nflush;
  endtask

  task automatic fresh(input int lat, input int lvl);
    @(negedge clk) begin latency_ms = 9'(lat); fifo_level = '0; end
    @(negedge clk) fifo_level = 12'(lvl);
    idle(1);
    mark = nflush;
  endtask

  task automatic t_reset_default;
    checks++;
    if (flush_req !== 1'b0) begin
      errors++;
      $display("FAIL R1: flush_req in reset actual %b expected 0", flush_req);
    end
    @(negedge clk) rst_n = 1'b1;
    #1;
    checks++;
    if (flush_req !== 1'b0) begin
      errors++;
      $display("FAIL R1: flush_req after reset actual %b expected 0", flush_req);
    end
    mark = nflush;
    latency_ms = 9'd1;
    ticks(127);
    expect_flushes(0, "R1 default 127 ticks");
    ticks(1);
    expect_flushes(1, "R1 default 128th tick");
  endtask

  task automatic t_period;
    ticks(7);
    expect_flushes(0, "R2 seven ticks");
    ticks(1);
    expect_flushes(1, "R2 eighth tick");
    ticks(8);
    expect_flushes(1, "R8 repeat period");
    ticks(16);
    expect_flushes(2, "R8 two more periods");
  endtask

  task automatic t_zero;
    fresh(0, 4);
    ticks(4);
    expect_flushes(4, "R3 every tick");
    @(negedge clk) begin uframe_tick = 1'b1; pkt_taken = 1'b1; end
    @(negedge clk) begin uframe_tick = 1'b0; pkt_taken = 1'b0; end
    expect_flushes(1, "R3 tick with restart");
  endtask

  task automatic t_empty;
    fresh(1, 3);
    @(negedge clk) fifo_level = '0;
    ticks(16);
    expect_flushes(0, "R4 empty fifo");
    @(negedge clk) fifo_level = 12'd2;
    ticks(8);
    expect_flushes(1, "R4 refill then period");
  endtask

  task automatic t_full;
    fresh(1, 5);
    ticks(5);
    @(negedge clk) pkt_full = 1'b1;
    ticks(10);
    expect_flushes(0, "R5 full packet pending");
    @(negedge clk) pkt_full = 1'b0;
    ticks(7);
    expect_flushes(0, "R5 timer cleared");
    ticks(1);
    expect_flushes(1, "R5 count resumes");
  endtask

  task automatic t_restart;
    fresh(1, 5);
    ticks(5);
    @(negedge clk) fifo_level = 12'd6;
    ticks(7);
    expect_flushes(0, "R6 arrival restart");
    ticks(1);
    expect_flushes(1, "R6 period after arrival");
    ticks(5);
    @(negedge clk) pkt_taken = 1'b1;
    @(negedge clk) pkt_taken = 1'b0;
    ticks(7);
    expect_flushes(0, "R6 taken restart");
    ticks(1);
    expect_flushes(1, "R6 period after taken");
    ticks(7);
    @(negedge clk) begin uframe_tick = 1'b1; pkt_taken = 1'b1; end
    @(negedge clk) begin uframe_tick = 1'b0; pkt_taken = 1'b0; end
    expect_flushes(0, "R6 restart wins over expiry");
    ticks(7);
    expect_flushes(0, "R6 fresh period short");
    ticks(1);
    expect_flushes(1, "R6 fresh period done");
    ticks(5);
    @(negedge clk) fifo_level = 12'd3;
    ticks(3);
    expect_flushes(1, "R9 drain keeps count");
  endtask

  task automatic t_latency_change;
    fresh(1, 5);
    ticks(2);
    @(negedge clk) latency_ms = 9'd2;
    ticks(6);
    expect_flushes(1, "R7 old value until restart");
    ticks(15);
    expect_flushes(0, "R7 new value 15 ticks");
    ticks(1);
    expect_flushes(1, "R7 new value 16th tick");
    fresh(300, 5);
    ticks(2047);
    expect_flushes(0, "R7 clamp 2047 ticks");
    ticks(1);
    expect_flushes(1, "R7 clamp 2048th tick");
  endtask

  initial begin
    latency_ms = 9'd1;
    fifo_level = 12'd3;
    idle(3);
    t_reset_default();
    t_period();
    t_zero();
    t_empty();
    t_full();
    t_restart();
    t_latency_change();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule